// File: doc/BRIEF.md
# Interrupt Cause Status Controller

This block holds a mask of pending interrupt causes and drives a single level-sensitive interrupt line toward the host. Causes enter the mask from two directions. Software can write any value to a raise register, and every 1 bit in that value becomes pending. Two hardware completion events can also set fixed cause bits: the end of a factorial computation and the end of a DMA transfer. Each of these events counts only while its own interrupt enable is set.

Software reads the pending mask from a read-only status register. It removes causes by writing those same bits to an acknowledge register, and the write leaves every other pending bit alone. The line toward the host stays high for as long as any cause is pending. When a hardware event and an acknowledge land on the same bit in the same cycle, the new event is kept, so a completion is never lost.

Top module: `irqStatusCtrl`

## Requirements
- R1: After reset the pending mask reads 0 and `irqOut` is low.
- R2: A write to the raise register (offset 0x60) makes every 1 bit of the written value pending. The mask is readable at offset 0x24 after the next rising clock edge.
- R3: A raise write does not clear bits that are already pending. The new mask is the OR of the old mask and the written value.
- R4: A write to the acknowledge register (offset 0x64) clears exactly the bits that are 1 in the written value. All other pending bits are unchanged.
- R5: `irqOut` is high exactly when the pending mask is nonzero. It changes on the clock edge that registers the raise, acknowledge or hardware event.
- R6: A `factDone` pulse while `factIrqEn` is high sets cause bit 0 (value 0x1). Without the enable the pulse has no effect on the mask.
- R7: A `dmaDone` pulse while `dmaIrqEn` is high sets cause bit 8 (value 0x100). Without the enable the pulse has no effect on the mask.
- R8: If an enabled hardware event and an acknowledge of the same bit occur in the same cycle, the bit remains pending.
- R9: Writes to any offset other than 0x60 and 0x64 leave the mask unchanged. This includes a write to the status offset 0x24.
- R10: A read of any offset other than 0x24 returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regWrEn | input | 1 | Register write strobe, one cycle per write |
| regWrAddr | input | ADDR_W (8) | Write byte offset |
| regWrData | input | DATA_W (32) | Write data |
| regRdAddr | input | ADDR_W (8) | Read byte offset |
| regRdData | output | DATA_W (32) | Combinational read data |
| factDone | input | 1 | Factorial completion pulse |
| factIrqEn | input | 1 | Interrupt enable for factorial completion |
| dmaDone | input | 1 | DMA completion pulse |
| dmaIrqEn | input | 1 | Interrupt enable for DMA completion |
| irqOut | output | 1 | Level interrupt to the host |

## Verification
The assertions assume that a write lasts exactly one cycle. They also assume that its address and data are valid whenever `regWrEn` is high. The properties for clearing and for unrelated writes are conditioned on no enabled hardware event occurring in the same cycle, because such an event may legally set bits at that moment. The directed stimulus drives every write and every event for a single cycle, changing inputs only on the falling edge. Hardware events coincide with an acknowledge only in the scenario written for that collision.

// File: rtl/irqStatPkg.sv
package irqStatPkg;

  // Strobes passed from the decode/control side to the datapath.
  typedef struct packed {
    logic raiseWr;  // raise register written this cycle
    logic ackWr;    // acknowledge register written this cycle
    logic factHit;  // enabled factorial completion
    logic dmaHit;   // enabled DMA completion
  } irqStrobes_t;

endpackage

// File: rtl/irqStatCtrl.sv
module irqStatCtrl
  import irqStatPkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int RAISE_OFS = 'h60,
  parameter int ACK_OFS   = 'h64
) (
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic              factDone,
  input  logic              factIrqEn,
  input  logic              dmaDone,
  input  logic              dmaIrqEn,
  output irqStrobes_t       strobes
);

  localparam logic [ADDR_W-1:0] RaiseAddr = ADDR_W'(RAISE_OFS);
  localparam logic [ADDR_W-1:0] AckAddr   = ADDR_W'(ACK_OFS);

  always_comb begin
    strobes         = '0;
    strobes.raiseWr = wrEn && (wrAddr == RaiseAddr);
    strobes.ackWr   = wrEn && (wrAddr == AckAddr);
    strobes.factHit = factDone && factIrqEn;
    strobes.dmaHit  = dmaDone && dmaIrqEn;
  end

endmodule

// File: rtl/irqStatDpath.sv
module irqStatDpath
  import irqStatPkg::*;
#(
  parameter int DATA_W     = 32,
  parameter int ADDR_W     = 8,
  parameter int STATUS_OFS = 'h24,
  parameter int FACT_BIT   = 0,
  parameter int DMA_BIT    = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  irqStrobes_t       strobes,
  input  logic [DATA_W-1:0] wrData,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [DATA_W-1:0] rdData,
  output logic [DATA_W-1:0] pendingMask,
  output logic              irqOut
);

  localparam logic [ADDR_W-1:0] StatusAddr = ADDR_W'(STATUS_OFS);

  logic [DATA_W-1:0] hwMask;
  logic [DATA_W-1:0] raiseMask;
  logic [DATA_W-1:0] clearMask;
  logic [DATA_W-1:0] nextMask;

  // One generated cell per cause bit: the hardware sources map to fixed bits.
  for (genvar b = 0; b < DATA_W; b++) begin : g_hwBit
    if (b == FACT_BIT && b == DMA_BIT) begin : g_both
      assign hwMask[b] = strobes.factHit | strobes.dmaHit;
    end else if (b == FACT_BIT) begin : g_fact
      assign hwMask[b] = strobes.factHit;
    end else if (b == DMA_BIT) begin : g_dma
      assign hwMask[b] = strobes.dmaHit;
    end else begin : g_none
      assign hwMask[b] = 1'b0;
    end
  end

  assign raiseMask = strobes.raiseWr ? wrData : '0;
  assign clearMask = strobes.ackWr   ? wrData : '0;

  // Clear first, then set: any same-cycle raise beats the acknowledge.
  assign nextMask = (pendingMask & ~clearMask) | raiseMask | hwMask;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) pendingMask <= '0;
    else       pendingMask <= nextMask;
  end

  assign irqOut = |pendingMask;
  assign rdData = (rdAddr == StatusAddr) ? pendingMask : '0;

endmodule

// File: rtl/irqStatusCtrl.sv
module irqStatusCtrl
  import irqStatPkg::*;
#(
  parameter int DATA_W     = 32,
  parameter int ADDR_W     = 8,
  parameter int STATUS_OFS = 'h24,
  parameter int RAISE_OFS  = 'h60,
  parameter int ACK_OFS    = 'h64,
  parameter int FACT_BIT   = 0,
  parameter int DMA_BIT    = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regWrAddr,
  input  logic [DATA_W-1:0] regWrData,
  input  logic [ADDR_W-1:0] regRdAddr,
  output logic [DATA_W-1:0] regRdData,
  input  logic              factDone,
  input  logic              factIrqEn,
  input  logic              dmaDone,
  input  logic              dmaIrqEn,
  output logic              irqOut
);

  irqStrobes_t       strobes;
  logic [DATA_W-1:0] pendingMask;

  irqStatCtrl #(
    .ADDR_W   (ADDR_W),
    .RAISE_OFS(RAISE_OFS),
    .ACK_OFS  (ACK_OFS)
  ) ctrl (
    .wrEn     (regWrEn),
    .wrAddr   (regWrAddr),
    .factDone (factDone),
    .factIrqEn(factIrqEn),
    .dmaDone  (dmaDone),
    .dmaIrqEn (dmaIrqEn),
    .strobes  (strobes)
  );

  irqStatDpath #(
    .DATA_W    (DATA_W),
    .ADDR_W    (ADDR_W),
    .STATUS_OFS(STATUS_OFS),
    .FACT_BIT  (FACT_BIT),
    .DMA_BIT   (DMA_BIT)
  ) dpath (
    .clk        (clk),
    .rstN       (rstN),
    .strobes    (strobes),
    .wrData     (regWrData),
    .rdAddr     (regRdAddr),
    .rdData     (regRdData),
    .pendingMask(pendingMask),
    .irqOut     (irqOut)
  );

endmodule

// File: rtl/irqStatusCtrl_checker.sv
module irqStatusCtrl_checker #(
  parameter int DATA_W    = 32,
  parameter int ADDR_W    = 8,
  parameter int RAISE_OFS = 'h60,
  parameter int ACK_OFS   = 'h64,
  parameter int FACT_BIT  = 0,
  parameter int DMA_BIT   = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              regWrEn,
  input logic [ADDR_W-1:0] regWrAddr,
  input logic [DATA_W-1:0] regWrData,
  input logic              factDone,
  input logic              factIrqEn,
  input logic              dmaDone,
  input logic              dmaIrqEn,
  input logic [DATA_W-1:0] pendingMask,
  input logic              irqOut
);

  logic hwEvent;
  logic isRaise;
  logic isAck;
  assign hwEvent = (factDone && factIrqEn) || (dmaDone && dmaIrqEn);
  assign isRaise = regWrEn && (regWrAddr == ADDR_W'(RAISE_OFS));
  assign isAck   = regWrEn && (regWrAddr == ADDR_W'(ACK_OFS));

  // R2: raised bits are pending after the edge
  a_r2_raise_sets: assert property (@(posedge clk) disable iff (!rstN)
    isRaise |=> ((pendingMask & $past(regWrData)) == $past(regWrData)));

  // R3: without an acknowledge, no pending bit drops
  a_r3_sticky: assert property (@(posedge clk) disable iff (!rstN)
    !isAck |=> ((pendingMask & $past(pendingMask)) == $past(pendingMask)));

  // R4: acknowledged bits are cleared when nothing re-raises them
  a_r4_ack_clears: assert property (@(posedge clk) disable iff (!rstN)
    (isAck && !hwEvent) |=> ((pendingMask & $past(regWrData)) == '0));

  // R5: a nonzero raise write leaves the line high
  a_r5_irq_after_raise: assert property (@(posedge clk) disable iff (!rstN)
    (isRaise && (regWrData != '0)) |=> irqOut);

  // R6: enabled factorial completion sets its bit
  a_r6_fact_sets: assert property (@(posedge clk) disable iff (!rstN)
    (factDone && factIrqEn) |=> pendingMask[FACT_BIT]);

  // R7 and R8: enabled DMA completion sets its bit even against an acknowledge
  a_r8_dma_wins: assert property (@(posedge clk) disable iff (!rstN)
    (dmaDone && dmaIrqEn) |=> pendingMask[DMA_BIT]);

  // R9: nothing else changes the mask
  a_r9_quiet_stable: assert property (@(posedge clk) disable iff (!rstN)
    (!isRaise && !isAck && !hwEvent) |=> $stable(pendingMask));

endmodule

bind irqStatusCtrl irqStatusCtrl_checker #(
  .DATA_W   (DATA_W),
  .ADDR_W   (ADDR_W),
  .RAISE_OFS(RAISE_OFS),
  .ACK_OFS  (ACK_OFS),
  .FACT_BIT (FACT_BIT),
  .DMA_BIT  (DMA_BIT)
) chk (
  .clk        (clk),
  .rstN       (rstN),
  .regWrEn    (regWrEn),
  .regWrAddr  (regWrAddr),
  .regWrData  (regWrData),
  .factDone   (factDone),
  .factIrqEn  (factIrqEn),
  .dmaDone    (dmaDone),
  .dmaIrqEn   (dmaIrqEn),
  .pendingMask(pendingMask),
  .irqOut     (irqOut)
);

// File: tb/irqStatusCtrl_test.sv
module irqStatusCtrl_test;

  localparam int CLK_PERIOD = 10;
  localparam logic [7:0] STATUS = 8'h24;
  localparam logic [7:0] RAISE  = 8'h60;
  localparam logic [7:0] ACK    = 8'h64;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWrEn = 1'b0;
  logic [7:0]  regWrAddr = '0;
  logic [31:0] regWrData = '0;
  logic [7:0]  regRdAddr = STATUS;
  logic [31:0] regRdData;
  logic        factDone = 1'b0;
  logic        factIrqEn = 1'b0;
  logic        dmaDone = 1'b0;
  logic        dmaIrqEn = 1'b0;
  logic        irqOut;

  int checks = 0;
  int fails  = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  irqStatusCtrl uut (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regWrAddr(regWrAddr),
    .regWrData(regWrData), .regRdAddr(regRdAddr), .regRdData(regRdData),
    .factDone(factDone), .factIrqEn(factIrqEn), .dmaDone(dmaDone),
    .dmaIrqEn(dmaIrqEn), .irqOut(irqOut)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // One cycle of stimulus, applied at a falling edge, released at the next one.
  task automatic step(logic we, logic [7:0] a, logic [31:0] d,
                      logic fd, logic fe, logic dd, logic de);
    regWrEn = we; regWrAddr = a; regWrData = d;
    factDone = fd; factIrqEn = fe; dmaDone = dd; dmaIrqEn = de;
    @(negedge clk);
    regWrEn = 1'b0; factDone = 1'b0; dmaDone = 1'b0;
    factIrqEn = 1'b0; dmaIrqEn = 1'b0;
  endtask

  task automatic expectState(string req, logic [31:0] mask);
    regRdAddr = STATUS;
    #1;
    check(req, regRdData, mask);
    check(req, 32'(irqOut), 32'(mask != 0));
  endtask

  task automatic testReset();
    expectState("R1", 32'h0);
  endtask

  task automatic testRaise();
    step(1, RAISE, 32'h5, 0, 0, 0, 0);
    expectState("R2", 32'h5);
    step(1, RAISE, 32'h30, 0, 0, 0, 0);
    expectState("R3", 32'h35);
    step(1, RAISE, 32'h1, 0, 0, 0, 0);
    expectState("R3", 32'h35);
  endtask

  task automatic testAck();
    step(1, ACK, 32'h4, 0, 0, 0, 0);
    expectState("R4", 32'h31);
    step(1, ACK, 32'hC0, 0, 0, 0, 0);
    expectState("R4", 32'h31);
    step(1, ACK, 32'h31, 0, 0, 0, 0);
    expectState("R5", 32'h0);
  endtask

  task automatic testFactorial();
    step(0, 8'h0, 32'h0, 1, 0, 0, 0);
    expectState("R6", 32'h0);
    step(0, 8'h0, 32'h0, 1, 1, 0, 0);
    expectState("R6", 32'h1);
    step(1, ACK, 32'h1, 0, 0, 0, 0);
    expectState("R6", 32'h0);
  endtask

  task automatic testDma();
    step(0, 8'h0, 32'h0, 0, 0, 1, 0);
    expectState("R7", 32'h0);
    step(0, 8'h0, 32'h0, 0, 0, 1, 1);
    expectState("R7", 32'h100);
  endtask

  task automatic testCollision();
    step(1, ACK, 32'h100, 0, 0, 1, 1);
    expectState("R8", 32'h100);
    step(1, ACK, 32'h100, 0, 0, 0, 0);
    expectState("R8", 32'h0);
  endtask

  task automatic testOtherWrites();
    step(1, RAISE, 32'h8, 0, 0, 0, 0);
    step(1, STATUS, 32'hFFFF_FFFF, 0, 0, 0, 0);
    expectState("R9", 32'h8);
    step(1, 8'h68, 32'hFFFF_FFFF, 0, 0, 0, 0);
    expectState("R9", 32'h8);
  endtask

  task automatic testOtherReads();
    regRdAddr = RAISE;
    #1;
    check("R10", regRdData, 32'h0);
    regRdAddr = 8'h00;
    #1;
    check("R10", regRdData, 32'h0);
    regRdAddr = STATUS;
  endtask

  initial begin
    #(CLK_PERIOD * 5000);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    testReset();
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testRaise();
    testAck();
    testFactorial();
    testDma();
    testCollision();
    testOtherWrites();
    testOtherReads();
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule